// File: doc/BRIEF.md
# Processor-to-Fabric Word Handoff Synchronizer

This block moves one data word at a time from a processor running on a slow clock into logic running on a faster, unrelated clock. The processor writes the word into a source-side holding register and then announces it by driving a one-bit ready flag from low to high. The fast side passes that flag through a flip-flop synchronizer, detects its rising edge one flop later, and uses the resulting one-cycle enable to copy the held word into a capture register while raising a one-cycle valid strobe.

A parameter selects one of two ways to announce a word. In manual mode, software writes the flag register with 0 and then with 1. In auto mode, every write to the data register raises the flag for one source cycle, and writes to the flag register are ignored. In both modes the scheme relies on the destination clock being faster than the source clock. It also relies on the held word staying unchanged until the capture has taken place.

Top module: `reg_handoff_sync`

## Requirements
- R1: After reset, `dst_data` is all zeros and `dst_valid` is 0.
- R2: A source write with `src_sel`=0 loads the data register, and a write with `src_sel`=1 loads the flag register from `src_wdata[0]`. In manual mode a data write alone produces no `dst_valid` pulse.
- R3: In manual mode, writing the flag as 0 and then as 1 produces exactly one `dst_valid` pulse, one destination cycle wide, and `dst_data` then equals the held word.
- R4: `dst_valid` rises within five destination cycles after the source edge that raises the flag.
- R5: Writing 1 to a flag that is already 1 causes no capture. A new capture needs the flag to fall and rise again, and only a synchronized high flag can cause one.
- R6: `dst_data` changes only in a cycle in which `dst_valid` is high. At all other times it holds the last captured word.
- R7: In auto mode, each data write yields exactly one capture of that word, with no flag writes needed.
- R8: In auto mode, writes to the flag register have no effect: no capture occurs and `dst_data` is unchanged.
- R9: Over a sequence of transfers, every word announced appears at `dst_data` exactly once, in the order written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Processor-side clock |
| src_rst_n | input | 1 | Processor-side asynchronous active-low reset |
| src_we | input | 1 | Write enable for the source registers |
| src_sel | input | 1 | Register select: 0 data register, 1 flag register |
| src_wdata | input | DATA_W | Write data; bit 0 is the flag value when `src_sel`=1 |
| dst_clk | input | 1 | Fast fabric-side clock |
| dst_rst_n | input | 1 | Fabric-side asynchronous active-low reset |
| dst_data | output | DATA_W | Capture register holding the last transferred word |
| dst_valid | output | 1 | One-cycle strobe marking a new word in `dst_data` |

## Verification
The source can rewrite the held data register in the same stretch of time in which the destination is still synchronizing the previous flag edge. Loading the next word and capturing the current word therefore meet in one window. The bench provokes this by issuing a data write for the next word right after each handoff, with the flag still high, and then sweeping every 8-bit value in both modes. It judges the result by requiring that the early write causes no pulse and leaves `dst_data` on the old word, and that each announced word is then captured exactly once, in order, within the latency bound.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Source register select decoded from the one-bit select pin.
  typedef enum logic {
    HS_SEL_DATA = 1'b0,
    HS_SEL_FLAG = 1'b1
  } hs_sel_e;

endpackage

// File: rtl/hs_sync.sv
// Chain of asynchronously cleared flops clocked by the receiving clock.
// Used both for the flag synchronizer and, with d tied high, for reset release.
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb chain_d[i] = d;
    end else begin : g_next
      always_comb chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q[i] <= 1'b0;
      end else begin
        chain_q[i] <= chain_d[i];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hs_src_regs.sv
// Processor-side data and flag registers.
module hs_src_regs
  import hs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit AUTO_FLAG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  hs_sel_e           sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q
);

  logic              data_wr;
  logic [DATA_W-1:0] data_d;
  logic              flag_d;

  assign data_wr = we & (sel == HS_SEL_DATA);

  always_comb begin
    data_d = data_q;
    if (data_wr) begin
      data_d = wdata;
    end
  end

  if (AUTO_FLAG) begin : g_auto
    // Flag follows data writes: high for the source cycle after each one.
    always_comb flag_d = data_wr;
  end else begin : g_manual
    logic flag_wr;
    assign flag_wr = we & (sel == HS_SEL_FLAG);
    always_comb begin
      flag_d = flag_q;
      if (flag_wr) begin
        flag_d = wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/hs_capture.sv
// Edge detect on the synchronized flag and the destination capture register.
module hs_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_in,
  input  logic [DATA_W-1:0] hold_data,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid
);

  logic              edge_q;
  logic              load_en;
  logic [DATA_W-1:0] cap_d;

  always_comb begin
    load_en = armed_in & ~edge_q;
    cap_d   = cap_data;
    if (load_en) begin
      cap_d = hold_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q    <= 1'b0;
      cap_data  <= '0;
      cap_valid <= 1'b0;
    end else begin
      edge_q    <= armed_in;
      cap_data  <= cap_d;
      cap_valid <= load_en;
    end
  end

endmodule

// File: rtl/reg_handoff_sync.sv
module reg_handoff_sync
  import hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit AUTO_FLAG   = 1'b0
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_we,
  input  logic              src_sel,
  input  logic [DATA_W-1:0] src_wdata,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_valid
);

  localparam int RST_STAGES  = 2;
  localparam int FLAG_STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic              src_rst_q_n;
  logic              dst_rst_q_n;
  hs_sel_e           sel_e;
  logic [DATA_W-1:0] src_data;
  logic              src_flag;
  logic              sync_flag;

  assign sel_e = hs_sel_e'(src_sel);

  // Reset asserted asynchronously, released on each domain's own clock.
  hs_sync #(.STAGES(RST_STAGES)) u_src_rst (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (1'b1),
    .q     (src_rst_q_n)
  );

  hs_sync #(.STAGES(RST_STAGES)) u_dst_rst (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (1'b1),
    .q     (dst_rst_q_n)
  );

  hs_src_regs #(.DATA_W(DATA_W), .AUTO_FLAG(AUTO_FLAG)) u_src (
    .clk    (src_clk),
    .rst_n  (src_rst_q_n),
    .we     (src_we),
    .sel    (sel_e),
    .wdata  (src_wdata),
    .data_q (src_data),
    .flag_q (src_flag)
  );

  hs_sync #(.STAGES(FLAG_STAGES)) u_flag_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_q_n),
    .d     (src_flag),
    .q     (sync_flag)
  );

  hs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (dst_clk),
    .rst_n     (dst_rst_q_n),
    .armed_in  (sync_flag),
    .hold_data (src_data),
    .cap_data  (dst_data),
    .cap_valid (dst_valid)
  );

endmodule

// File: rtl/hs_checker.sv
module hs_checker
  import hs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit AUTO_FLAG = 1'b0
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              src_we,
  input logic              src_sel,
  input logic              src_wdata0,
  input logic              src_flag,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              sync_flag,
  input logic [DATA_W-1:0] dst_data,
  input logic              dst_valid
);

  // R3: the strobe never lasts two destination cycles.
  p_single_pulse_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid);

  // R6: the captured word moves only together with the strobe.
  p_hold_r6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$stable(dst_data) |-> dst_valid);

  // R5: a capture is always preceded by a synchronized high flag.
  p_capture_after_sync_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |-> $past(sync_flag));

  // R2 and R8: the flag rises only from the write that the mode allows.
  p_flag_source_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(src_flag) |-> $past(src_we && (AUTO_FLAG ? (src_sel == HS_SEL_DATA)
                                                   : ((src_sel == HS_SEL_FLAG) && src_wdata0))));

endmodule

bind reg_handoff_sync hs_checker #(.DATA_W(DATA_W), .AUTO_FLAG(AUTO_FLAG)) u_chk (
  .src_clk    (src_clk),
  .src_rst_n  (src_rst_n),
  .src_we     (src_we),
  .src_sel    (src_sel),
  .src_wdata0 (src_wdata[0]),
  .src_flag   (src_flag),
  .dst_clk    (dst_clk),
  .dst_rst_n  (dst_rst_n),
  .sync_flag  (sync_flag),
  .dst_data   (dst_data),
  .dst_valid  (dst_valid)
);

// File: tb/sim_reg_handoff_sync.sv
`timescale 1ns/100ps
module sim_reg_handoff_sync;

  localparam int DST_PERIOD = 4;
  localparam int SRC_PERIOD = 7;
  localparam int DW         = 8;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n, dst_rst_n;
  logic          we0, we1, sel;
  logic [DW-1:0] wdata;
  logic [DW-1:0] d0, d1;
  logic          v0, v1;

  int checks = 0;
  int errors = 0;
  int n0 = 0;
  int n1 = 0;
  logic [DW-1:0] last0 = '0;
  logic [DW-1:0] last1 = '0;
  logic pv0 = 1'b0;
  logic pv1 = 1'b0;
  bit done = 1'b0;

  initial forever #(DST_PERIOD/2) dst_clk = ~dst_clk;
  initial begin #1; forever #(SRC_PERIOD/2.0) src_clk = ~src_clk; end

  reg_handoff_sync #(.DATA_W(DW), .AUTO_FLAG(1'b0)) u0 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_we(we0), .src_sel(sel),
    .src_wdata(wdata), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_data(d0), .dst_valid(v0));

  reg_handoff_sync #(.DATA_W(DW), .AUTO_FLAG(1'b1)) u1 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_we(we1), .src_sel(sel),
    .src_wdata(wdata), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_data(d1), .dst_valid(v1));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic src_write(input int inst, input logic s, input logic [DW-1:0] v);
    @(negedge src_clk);
    sel   = s;
    wdata = v;
    if (inst == 0) we0 = 1'b1; else we1 = 1'b1;
    @(posedge src_clk);
    #1;
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  task automatic dst_wait(input int n);
    repeat (n) @(negedge dst_clk);
  endtask

  // Pulse monitor on the falling destination edge.
  always @(negedge dst_clk) begin
    if (v0 === 1'b1) begin
      n0++;
      last0 = d0;
      check(!pv0, "R3 strobe one cycle wide (manual)", int'(pv0), 0);
    end
    if (v1 === 1'b1) begin
      n1++;
      last1 = d1;
      check(!pv1, "R3 strobe one cycle wide (auto)", int'(pv1), 0);
    end
    pv0 = (v0 === 1'b1);
    pv1 = (v1 === 1'b1);
  end

  initial begin
    logic [DW-1:0] w;
    logic [DW-1:0] prev;
    int base;
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    we0 = 1'b0; we1 = 1'b0; sel = 1'b0; wdata = '0;
    dst_wait(5);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    dst_wait(6);
    check(d0 == '0, "R1 reset data (manual)", d0, 0);
    check(v0 == 1'b0, "R1 reset valid (manual)", v0, 0);
    check(d1 == '0, "R1 reset data (auto)", d1, 0);
    check(v1 == 1'b0, "R1 reset valid (auto)", v1, 0);

    // Manual mode: all 256 words, each preceded by an early data write.
    prev = '0;
    for (int i = 0; i < 256; i++) begin
      w    = DW'(i * 37 + 11);
      base = n0;
      src_write(0, 1'b0, w);
      dst_wait(6);
      check(n0 == base, "R2 data write alone gives no strobe", n0, base);
      check(d0 == prev, "R6 capture holds old word", d0, prev);
      src_write(0, 1'b1, 8'hFE);
      src_write(0, 1'b1, {w[DW-1:1], 1'b1});
      dst_wait(5);
      check(n0 == base + 1, "R4 one capture within latency bound", n0, base + 1);
      check(last0 == w, "R3 captured word", last0, w);
      check(d0 == w, "R9 word in order (manual)", d0, w);
      prev = w;
    end

    // R5: rewriting a high flag does nothing; a fall then rise re-arms.
    base = n0;
    src_write(0, 1'b1, 8'h01);
    dst_wait(6);
    check(n0 == base, "R5 high flag rewritten gives no capture", n0, base);
    src_write(0, 1'b1, 8'h00);
    src_write(0, 1'b1, 8'h01);
    dst_wait(5);
    check(n0 == base + 1, "R5 re-armed flag captures", n0, base + 1);
    check(d0 == prev, "R5 re-captured word", d0, prev);

    // Auto mode: each data write is a handoff.
    for (int i = 0; i < 256; i++) begin
      w    = DW'(i * 91 + 3);
      base = n1;
      src_write(1, 1'b0, w);
      dst_wait(5);
      check(n1 == base + 1, "R7 auto capture per data write", n1, base + 1);
      check(d1 == w, "R7 auto captured word", d1, w);
      check(last1 == w, "R9 word in order (auto)", last1, w);
    end

    // R8: flag writes in auto mode are ignored.
    base = n1;
    prev = d1;
    src_write(1, 1'b1, 8'h01);
    src_write(1, 1'b1, 8'h00);
    src_write(1, 1'b1, 8'hFF);
    dst_wait(6);
    check(n1 == base, "R8 flag write ignored in auto mode", n1, base);
    check(d1 == prev, "R8 data unchanged in auto mode", d1, prev);

    check(n0 == 257, "R9 total captures (manual)", n0, 257);
    check(n1 == 256, "R9 total captures (auto)", n1, 256);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(DST_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule